// File: doc/BRIEF.md
# Timing Reference Qualification and Holdover Controller

This block decides, once per clock, whether the local oscillator may be steered by an incoming timing reference, and which of two references (primary at index 0, backup at index 1) it follows. Each reference supplies four inputs: a lock flag, a pulse-per-second present flag, a phase-jump strobe and a quality score. A local once-per-second strobe paces two sustain windows. One window decides how long a low score must last before the reference is dropped. The other decides how long a healthy, high score must last before the reference counts as qualified.

The controller moves through four operating modes: locked, degraded, holdover and recovery-slew. A returning reference always passes through recovery-slew, so the servo can bring the phase in gradually instead of stepping it. Every change of mode or source produces a one-cycle transition record. The record carries the mode and source before and after the change, plus a 3-bit reason. The quality scoring, the loop filter and the oscillator DAC sit outside this block.

Top module: `refQualCtrl`

## Requirements
- R1: After reset the block reports holdover (mode code 2), source 0, steering off and no transition record.
- R2: A reference counts as qualified only while its lock and PPS-present flags are both high, its score is at least `exitThr`, no jump strobe is present, and at least `exitWin` second ticks have passed under those conditions.
- R3: Holdover is left only for recovery-slew (mode 3) with cause 3 (restored), never straight to locked; `slewDone` in recovery-slew moves to locked (mode 0) with cause 4.
- R4: In locked, a score below `enterThr` on the active reference moves to degraded (mode 1) with cause 0. In degraded, a score at or above `exitThr` returns to locked with cause 3. A score between the two thresholds changes neither mode.
- R5: A score held below `enterThr` for `enterWin` second ticks drops the active reference with cause 0.
- R6: Loss of lock or of PPS on the active reference drops it in the next cycle with cause 1.
- R7: A jump strobe on the active reference drops it in the next cycle with cause 2. When several faults coincide, cause 1 wins over cause 2, and cause 2 wins over cause 0.
- R8: When the active reference is dropped and the other reference is qualified, the block switches source and enters recovery-slew. Otherwise it enters holdover and keeps the same source.
- R9: While neither reference is qualified, holdover persists with no source change and no record.
- R10: A `manualSwitch` pulse in locked, degraded or recovery-slew moves to the other source in recovery-slew with cause 5, provided that source is qualified. The pulse is ignored in holdover and when the other source is unqualified.
- R11: `steerEn` is high exactly in locked and recovery-slew. It is low in the same cycle that the mode reads holdover.
- R12: A transition record (`evtValid` for one cycle) appears in the same cycle as every mode or source change. It gives the previous and new mode, the previous and new source, and the cause. The cause codes are 0 score low, 1 lock lost, 2 phase jump, 3 restored, 4 slew complete and 5 manual switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | Local once-per-second strobe pacing the sustain windows |
| refLock | input | 2 | Lock flag per reference |
| refPpsOk | input | 2 | PPS-present flag per reference |
| refJump | input | 2 | Phase-jump strobe per reference |
| refScore | input | 2 x SCORE_W | Quality score per reference |
| enterThr | input | SCORE_W | Score below which a reference counts as low |
| exitThr | input | SCORE_W | Score at or above which a reference counts as good |
| enterWin | input | WIN_W | Ticks of low score before the reference is dropped |
| exitWin | input | WIN_W | Ticks of good health needed to qualify |
| manualSwitch | input | 1 | Request to move to the other reference |
| slewDone | input | 1 | Servo reports that phase alignment is complete |
| mode | output | 2 | 0 locked, 1 degraded, 2 holdover, 3 recovery-slew |
| srcSel | output | 1 | Active reference index |
| steerEn | output | 1 | Oscillator steering allowed |
| evtValid | output | 1 | Transition record strobe |
| evtPrevMode | output | 2 | Mode before the transition |
| evtNewMode | output | 2 | Mode after the transition |
| evtPrevSrc | output | 1 | Source before the transition |
| evtNewSrc | output | 1 | Source after the transition |
| evtCause | output | 3 | Reason code |

## Verification
The assertions assume that `enterThr` does not exceed `exitThr`, that the window registers stay constant between scenarios, and that `secTick`, `refJump`, `manualSwitch` and `slewDone` are single-cycle pulses. The stimulus sets the thresholds once, at 100 and 150. It changes flags only on falling edges and pulses each strobe for exactly one clock. It waits two cycles after each tick before it samples, so that the sustain counters and the mode register have both settled.

// File: rtl/refq_pkg.sv
package refq_pkg;
  localparam int NREF = 2;

  typedef enum logic [1:0] {
    MODE_LOCKED   = 2'd0,
    MODE_DEGRADED = 2'd1,
    MODE_HOLDOVER = 2'd2,
    MODE_SLEW     = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    CAUSE_SCORE_LOW = 3'd0,
    CAUSE_LOCK_LOST = 3'd1,
    CAUSE_JUMP      = 3'd2,
    CAUSE_RESTORED  = 3'd3,
    CAUSE_SLEW_DONE = 3'd4,
    CAUSE_MANUAL    = 3'd5
  } cause_e;

  // per-reference health summary, datapath -> control
  typedef struct packed {
    logic healthy;
    logic scoreLow;
    logic scoreGood;
    logic lowSustained;
    logic qualified;
  } refStat_t;

  // transition strobe, control -> datapath
  typedef struct packed {
    logic   fire;
    mode_e  prevMode;
    mode_e  newMode;
    logic   prevSrc;
    logic   newSrc;
    cause_e cause;
  } xfer_t;
endpackage

// File: rtl/refQualData.sv
module refQualData
  import refq_pkg::*;
#(
  parameter int SCORE_W = 8,
  parameter int WIN_W   = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           secTick,
  input  logic [NREF-1:0]                refLock,
  input  logic [NREF-1:0]                refPpsOk,
  input  logic [NREF-1:0]                refJump,
  input  logic [NREF-1:0][SCORE_W-1:0]   refScore,
  input  logic [SCORE_W-1:0]             enterThr,
  input  logic [SCORE_W-1:0]             exitThr,
  input  logic [WIN_W-1:0]               enterWin,
  input  logic [WIN_W-1:0]               exitWin,
  input  xfer_t                          xfer,
  output refStat_t [NREF-1:0]            stat,
  output xfer_t                          evtRec
);
  localparam logic [WIN_W-1:0] CNT_MAX = {WIN_W{1'b1}};

  for (genvar i = 0; i < NREF; i++) begin : g_ref
    logic [WIN_W-1:0] lowCnt;
    logic [WIN_W-1:0] goodCnt;
    logic healthy, scoreLow, scoreGood, goodNow;

    assign healthy   = refLock[i] & refPpsOk[i];
    assign scoreLow  = refScore[i] < enterThr;
    assign scoreGood = refScore[i] >= exitThr;
    assign goodNow   = healthy & scoreGood & ~refJump[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lowCnt  <= '0;
        goodCnt <= '0;
      end else begin
        if (!scoreLow)
          lowCnt <= '0;
        else if (secTick && lowCnt != CNT_MAX)
          lowCnt <= lowCnt + 1'b1;

        if (!goodNow)
          goodCnt <= '0;
        else if (secTick && goodCnt != CNT_MAX)
          goodCnt <= goodCnt + 1'b1;
      end
    end

    assign stat[i].healthy      = healthy;
    assign stat[i].scoreLow     = scoreLow;
    assign stat[i].scoreGood    = scoreGood;
    assign stat[i].lowSustained = scoreLow & (lowCnt >= enterWin);
    assign stat[i].qualified    = goodNow & (goodCnt >= exitWin);

    // R2
    qual_health_chk: assert property (@(posedge clk) disable iff (!rstN)
      stat[i].qualified |-> (refLock[i] && refPpsOk[i] && !refJump[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtRec <= '0;
    else       evtRec <= xfer;
  end

  // R12
  cause_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtRec.fire |-> (evtRec.cause <= CAUSE_MANUAL));
endmodule

// File: rtl/refQualFsm.sv
module refQualFsm
  import refq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  refStat_t [NREF-1:0]  stat,
  input  logic [NREF-1:0]      refJump,
  input  logic                 manualSwitch,
  input  logic                 slewDone,
  output mode_e                modeQ,
  output logic                 srcQ,
  output logic                 steerEn,
  output xfer_t                xfer
);
  mode_e    nMode;
  logic     nSrc;
  cause_e   nCause;
  refStat_t act, alt;
  logic     actJump, fault;
  cause_e   faultCause;

  assign act     = stat[srcQ];
  assign alt     = stat[~srcQ];
  assign actJump = refJump[srcQ];

  always_comb begin
    fault      = 1'b1;
    faultCause = CAUSE_LOCK_LOST;
    if (!act.healthy)          faultCause = CAUSE_LOCK_LOST;
    else if (actJump)          faultCause = CAUSE_JUMP;
    else if (act.lowSustained) faultCause = CAUSE_SCORE_LOW;
    else                       fault = 1'b0;
  end

  always_comb begin
    nMode  = modeQ;
    nSrc   = srcQ;
    nCause = CAUSE_SCORE_LOW;
    if (modeQ == MODE_HOLDOVER) begin
      if (act.qualified) begin
        nMode = MODE_SLEW; nCause = CAUSE_RESTORED;
      end else if (alt.qualified) begin
        nMode = MODE_SLEW; nSrc = ~srcQ; nCause = CAUSE_RESTORED;
      end
    end else if (fault) begin
      nCause = faultCause;
      if (alt.qualified) begin
        nMode = MODE_SLEW; nSrc = ~srcQ;
      end else begin
        nMode = MODE_HOLDOVER;
      end
    end else if (manualSwitch && alt.qualified) begin
      nMode = MODE_SLEW; nSrc = ~srcQ; nCause = CAUSE_MANUAL;
    end else begin
      case (modeQ)
        MODE_LOCKED: if (act.scoreLow) begin
          nMode = MODE_DEGRADED; nCause = CAUSE_SCORE_LOW;
        end
        MODE_DEGRADED: if (act.scoreGood) begin
          nMode = MODE_LOCKED; nCause = CAUSE_RESTORED;
        end
        MODE_SLEW: if (slewDone) begin
          nMode = MODE_LOCKED; nCause = CAUSE_SLEW_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_HOLDOVER;
      srcQ  <= 1'b0;
    end else begin
      modeQ <= nMode;
      srcQ  <= nSrc;
    end
  end

  assign steerEn       = (modeQ == MODE_LOCKED) || (modeQ == MODE_SLEW);
  assign xfer.fire     = (nMode != modeQ) || (nSrc != srcQ);
  assign xfer.prevMode = modeQ;
  assign xfer.newMode  = nMode;
  assign xfer.prevSrc  = srcQ;
  assign xfer.newSrc   = nSrc;
  assign xfer.cause    = nCause;

  // R3
  no_hold_to_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeQ) == MODE_HOLDOVER) |-> (modeQ != MODE_LOCKED));

  // R9
  hold_src_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_HOLDOVER && !stat[0].qualified && !stat[1].qualified)
      |=> (modeQ == MODE_HOLDOVER && $stable(srcQ)));

  // R6
  lock_loss_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_HOLDOVER && !act.healthy)
      |=> (modeQ == MODE_HOLDOVER || (modeQ == MODE_SLEW && srcQ != $past(srcQ))));

  // R7
  jump_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_HOLDOVER && actJump)
      |=> (modeQ == MODE_HOLDOVER || modeQ == MODE_SLEW));
endmodule

// File: rtl/refQualCtrl.sv
module refQualCtrl
  import refq_pkg::*;
#(
  parameter int SCORE_W = 8,
  parameter int WIN_W   = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         secTick,
  input  logic [1:0]                   refLock,
  input  logic [1:0]                   refPpsOk,
  input  logic [1:0]                   refJump,
  input  logic [1:0][SCORE_W-1:0]      refScore,
  input  logic [SCORE_W-1:0]           enterThr,
  input  logic [SCORE_W-1:0]           exitThr,
  input  logic [WIN_W-1:0]             enterWin,
  input  logic [WIN_W-1:0]             exitWin,
  input  logic                         manualSwitch,
  input  logic                         slewDone,
  output logic [1:0]                   mode,
  output logic                         srcSel,
  output logic                         steerEn,
  output logic                         evtValid,
  output logic [1:0]                   evtPrevMode,
  output logic [1:0]                   evtNewMode,
  output logic                         evtPrevSrc,
  output logic                         evtNewSrc,
  output logic [2:0]                   evtCause
);
  refStat_t [NREF-1:0] stat;
  xfer_t               xfer;
  xfer_t               evtRec;
  mode_e               modeQ;

  refQualData #(.SCORE_W(SCORE_W), .WIN_W(WIN_W)) u_data (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .refLock(refLock), .refPpsOk(refPpsOk), .refJump(refJump),
    .refScore(refScore), .enterThr(enterThr), .exitThr(exitThr),
    .enterWin(enterWin), .exitWin(exitWin),
    .xfer(xfer), .stat(stat), .evtRec(evtRec)
  );

  refQualFsm u_fsm (
    .clk(clk), .rstN(rstN), .stat(stat), .refJump(refJump),
    .manualSwitch(manualSwitch), .slewDone(slewDone),
    .modeQ(modeQ), .srcQ(srcSel), .steerEn(steerEn), .xfer(xfer)
  );

  assign mode        = modeQ;
  assign evtValid    = evtRec.fire;
  assign evtPrevMode = evtRec.prevMode;
  assign evtNewMode  = evtRec.newMode;
  assign evtPrevSrc  = evtRec.prevSrc;
  assign evtNewSrc   = evtRec.newSrc;
  assign evtCause    = evtRec.cause;

  // R12
  change_has_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(mode) || !$stable(srcSel)) |-> evtValid);

  // R12
  evt_matches_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtNewMode == mode && evtNewSrc == srcSel));

  // R11
  hold_no_steer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtNewMode == MODE_HOLDOVER) |-> !steerEn);
endmodule

// File: tb/tb_refQualCtrl.sv
module tb_refQualCtrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic [1:0] refLock = 2'b11;
  logic [1:0] refPpsOk = 2'b11;
  logic [1:0] refJump = 2'b00;
  logic [1:0][7:0] refScore;
  logic [7:0] enterThr = 8'd100;
  logic [7:0] exitThr = 8'd150;
  logic [7:0] enterWin = 8'd3;
  logic [7:0] exitWin = 8'd2;
  logic manualSwitch = 1'b0;
  logic slewDone = 1'b0;
  logic [1:0] mode, evtPrevMode, evtNewMode;
  logic srcSel, steerEn, evtValid, evtPrevSrc, evtNewSrc;
  logic [2:0] evtCause;

  int checks = 0;
  int fails = 0;
  int evtCount = 0;
  int lastPm, lastNm, lastPs, lastNs, lastCause;

  refQualCtrl dut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .refLock(refLock),
    .refPpsOk(refPpsOk), .refJump(refJump), .refScore(refScore),
    .enterThr(enterThr), .exitThr(exitThr), .enterWin(enterWin),
    .exitWin(exitWin), .manualSwitch(manualSwitch), .slewDone(slewDone),
    .mode(mode), .srcSel(srcSel), .steerEn(steerEn), .evtValid(evtValid),
    .evtPrevMode(evtPrevMode), .evtNewMode(evtNewMode),
    .evtPrevSrc(evtPrevSrc), .evtNewSrc(evtNewSrc), .evtCause(evtCause)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rstN && evtValid) begin
      evtCount++;
      lastPm = evtPrevMode; lastNm = evtNewMode;
      lastPs = evtPrevSrc;  lastNs = evtNewSrc;
      lastCause = evtCause;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doTick(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); secTick = 1'b1;
      @(negedge clk); secTick = 1'b0;
      idle(2);
    end
  endtask

  task automatic pulseSlew();
    @(negedge clk); slewDone = 1'b1;
    @(negedge clk); slewDone = 1'b0;
    idle(1);
  endtask

  task automatic pulseManual();
    @(negedge clk); manualSwitch = 1'b1;
    @(negedge clk); manualSwitch = 1'b0;
    idle(1);
  endtask

  task automatic checkState(string req, int m, int s, int st);
    check({req, " mode"}, mode, m);
    check({req, " src"}, srcSel, s);
    check({req, " steer"}, steerEn, st);
  endtask

  task automatic checkEvt(string req, int pm, int nm, int ps, int ns, int c);
    check({req, " evt prevMode"}, lastPm, pm);
    check({req, " evt newMode"}, lastNm, nm);
    check({req, " evt prevSrc"}, lastPs, ps);
    check({req, " evt newSrc"}, lastNs, ns);
    check({req, " evt cause"}, lastCause, c);
  endtask

  task automatic testReset();
    idle(2);
    checkState("R1", 2, 0, 0);
    check("R1 no evt", evtCount, 0);
  endtask

  task automatic testQualify();
    doTick(1);
    checkState("R2 one tick short", 2, 0, 0);
    doTick(1);
    checkState("R3 slew after qualify", 3, 0, 1);
    checkEvt("R3", 2, 3, 0, 0, 3);
    pulseSlew();
    checkState("R3 slew done", 0, 0, 1);
    checkEvt("R3", 3, 0, 0, 0, 4);
  endtask

  task automatic testHysteresis();
    int base;
    base = evtCount;
    @(negedge clk); refScore[0] = 8'd120; idle(2);
    checkState("R4 mid band locked", 0, 0, 1);
    check("R4 no evt mid band", evtCount, base);
    @(negedge clk); refScore[0] = 8'd90; idle(2);
    checkState("R4 degraded", 1, 0, 0);
    checkEvt("R4", 0, 1, 0, 0, 0);
    @(negedge clk); refScore[0] = 8'd120; idle(2);
    check("R4 stays degraded", mode, 1);
    @(negedge clk); refScore[0] = 8'd160; idle(2);
    checkState("R4 relocked", 0, 0, 1);
    checkEvt("R4", 1, 0, 0, 0, 3);
  endtask

  task automatic testSustain();
    @(negedge clk); refLock[1] = 1'b0; refScore[0] = 8'd90; idle(2);
    check("R5 degraded first", mode, 1);
    doTick(2);
    check("R5 window not met", mode, 1);
    doTick(1);
    checkState("R5 holdover", 2, 0, 0);
    checkEvt("R5", 1, 2, 0, 0, 0);
    @(negedge clk); refScore[0] = 8'd160;
    doTick(1);
    check("R3 still holdover", mode, 2);
    doTick(1);
    checkState("R3 slew not locked", 3, 0, 1);
    pulseSlew();
    check("R3 locked", mode, 0);
  endtask

  task automatic testLockLoss();
    @(negedge clk); refLock[1] = 1'b1;
    doTick(2);
    @(negedge clk); refLock[0] = 1'b0; idle(2);
    checkState("R8 switched", 3, 1, 1);
    checkEvt("R6", 0, 3, 0, 1, 1);
    pulseSlew();
    checkState("R8 locked on backup", 0, 1, 1);
  endtask

  task automatic testJump();
    @(negedge clk); refJump[1] = 1'b1;
    @(negedge clk); refJump[1] = 1'b0; idle(1);
    checkState("R7 holdover", 2, 1, 0);
    checkEvt("R7", 0, 2, 1, 1, 2);
  endtask

  task automatic testBothBad();
    int base;
    @(negedge clk); refLock[1] = 1'b0;
    base = evtCount;
    doTick(4);
    pulseManual();
    checkState("R9 holdover kept", 2, 1, 0);
    check("R9 no evt", evtCount, base);
    check("R10 manual ignored in holdover", evtCount, base);
    @(negedge clk); refLock[1] = 1'b1;
    doTick(2);
    checkState("R3 restored backup", 3, 1, 1);
    checkEvt("R3", 2, 3, 1, 1, 3);
    pulseSlew();
    check("R3 relocked", mode, 0);
  endtask

  task automatic testManual();
    int base;
    base = evtCount;
    pulseManual();
    checkState("R10 manual unqualified alt", 0, 1, 1);
    check("R10 no evt", evtCount, base);
    @(negedge clk); refLock[0] = 1'b1;
    doTick(2);
    pulseManual();
    checkState("R10 manual switch", 3, 0, 1);
    checkEvt("R10", 0, 3, 1, 0, 5);
    pulseSlew();
    checkState("R10 locked primary", 0, 0, 1);
  endtask

  task automatic testPpsAndPriority();
    @(negedge clk); refPpsOk[0] = 1'b0; idle(2);
    checkState("R6 pps loss", 3, 1, 1);
    checkEvt("R6", 0, 3, 0, 1, 1);
    @(negedge clk); refPpsOk[0] = 1'b1;
    @(negedge clk); refLock[1] = 1'b0; refJump[1] = 1'b1;
    @(negedge clk); refJump[1] = 1'b0; idle(1);
    checkState("R7 priority holdover", 2, 1, 0);
    check("R7 lock beats jump", lastCause, 1);
    check("R11 steer off in holdover", steerEn, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    refScore[0] = 8'd160;
    refScore[1] = 8'd160;
    idle(3);
    @(negedge clk); rstN = 1'b1;
    testReset();
    testQualify();
    testHysteresis();
    testSustain();
    testLockLoss();
    testJump();
    testBothBad();
    testManual();
    testPpsAndPriority();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule